// File: doc/BRIEF.md
# Serial Control and Readout Port

This block lets a host microcontroller talk to a digital audio receiver over a four-wire serial link: a serial clock, an active-high frame strobe, a data-in line and a data-out line. In every frame the host first shifts in an 8-bit address, least significant bit first. The address picks one of three accesses. The first loads an 8-bit command word. The second reads back the 32 captured channel-status bits. The third reads the 80-bit subcode/ID record together with its CRC flag.

A `mode` input picks between two framings. Each framing has its own set of three addresses and its own way of driving the data-out line. Framing 0 uses a pull-down style output: the pin is driven low only for a 0 bit and is otherwise left to a pull-up. Framing 1 uses a three-state output that is driven for the whole read.

The command word drives the receiver's control fields. One of these fields selects what a status pin carries. The captured words themselves arrive on parallel inputs.

All serial inputs are synchronised to the system clock, so the serial clock must run well below the system clock.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset, sys_stop, in_sel, stat_sel, out_fmt, ser_dout_oe and ser_dout_pull are all 0.
- R2: With mode=0, the address values 0xF7 (command load), 0xF8 (channel-status read) and 0xF9 (subcode read) are decoded. Each address is taken from the first 8 ser_din bits, sampled on rising ser_clk edges while ser_cs is high, least significant bit first.
- R3: With mode=1, the addresses are 0xEA (command load), 0xE9 (channel-status read) and 0xE8 (subcode read). Any other address, including those of the other framing, changes no command field and leaves the output undriven.
- R4: A command load takes the 8 bits after the address, LSB first. The command applies when ser_cs falls, and only if at least 8 data bits were given. Bits after the eighth are ignored. A frame with fewer than 8 data bits leaves the command unchanged.
- R5: Command bit 1 drives sys_stop and bit 2 drives in_sel. Bits 3 and 4 form stat_sel as {bit3,bit4}. Bits 5 and 6 form out_fmt as {bit5,bit6}. Bits 0 and 7 have no effect.
- R6: stat_out carries emph_bit when stat_sel=00, valid_bit when 01, raw_in1 when 10 and raw_in2 when 11.
- R7: A channel-status read presents one bit per falling ser_clk edge after the address: cs_word bit 0 first, through bit 31. With mode=1 a flag bit of 1 comes first. Bits beyond the payload read 0.
- R8: A subcode read, in either framing, presents sq_crc_ok first, then sq_word bits 0 through 79.
- R9: While lock_err is high during a channel-status read, every channel-status bit not yet presented reads 0.
- R10: With mode=0, ser_dout_oe stays 0 and ser_dout_pull is 1 exactly while the presented bit is 0. With mode=1, ser_dout_oe is 1 and ser_dout_pull is 0. Either way, the output is driven only from the first falling edge of a read until ser_cs falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | Framing select (0 or 1) |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs | input | 1 | Frame strobe, high during a transaction |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Read data bit |
| ser_dout_oe | output | 1 | Three-state drive enable (framing 1) |
| ser_dout_pull | output | 1 | Pull-low enable (framing 0) |
| cs_word | input | 32 | Captured channel-status bits |
| sq_word | input | 80 | Captured subcode/ID record |
| sq_crc_ok | input | 1 | Subcode CRC flag |
| lock_err | input | 1 | Lock lost indication |
| emph_bit | input | 1 | Emphasis bit source |
| valid_bit | input | 1 | Validity flag source |
| raw_in1 | input | 1 | Raw biphase stream, input 1 |
| raw_in2 | input | 1 | Raw biphase stream, input 2 |
| sys_stop | output | 1 | Stop request |
| in_sel | output | 1 | Input select (0 = input 1) |
| stat_sel | output | 2 | Status pin source select |
| out_fmt | output | 2 | Audio output format code |
| stat_out | output | 1 | Status pin value |

## Verification
The assertions assume four things about the inputs:
- ser_clk, ser_cs and ser_din stay at each level for several system clocks.
- ser_din is stable around each rising serial edge.
- `mode` does not change inside a frame.
- The parallel words hold steady while a read is running.

The stimulus keeps to these conditions. Every serial level is held for eight system clocks, data changes only while ser_clk is low, and mode and the random words are set between frames. lock_err is raised only in the low phase, right after a bit has been sampled.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int ADDR_W = 8;
  localparam int CMD_W  = 8;

  localparam logic [ADDR_W-1:0] F0_WR = 8'hF7;
  localparam logic [ADDR_W-1:0] F0_CS = 8'hF8;
  localparam logic [ADDR_W-1:0] F0_SQ = 8'hF9;
  localparam logic [ADDR_W-1:0] F1_WR = 8'hEA;
  localparam logic [ADDR_W-1:0] F1_CS = 8'hE9;
  localparam logic [ADDR_W-1:0] F1_SQ = 8'hE8;

  localparam logic [CMD_W-1:0] CMD_KEEP = 8'b0111_1110;
  localparam int BIT_STOP = 1;
  localparam int BIT_INSEL = 2;
  localparam int BIT_SSEL_HI = 3;
  localparam int BIT_SSEL_LO = 4;
  localparam int BIT_FMT_HI = 5;
  localparam int BIT_FMT_LO = 6;

  typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_CS, ACC_SQ} acc_e;

  function automatic acc_e addr_decode(input logic mode, input logic [ADDR_W-1:0] a);
    acc_e r;
    r = ACC_NONE;
    if (!mode) begin
      if (a == F0_WR) r = ACC_WR;
      else if (a == F0_CS) r = ACC_CS;
      else if (a == F0_SQ) r = ACC_SQ;
    end else begin
      if (a == F1_WR) r = ACC_WR;
      else if (a == F1_CS) r = ACC_CS;
      else if (a == F1_SQ) r = ACC_SQ;
    end
    return r;
  endfunction
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [STAGES:0][WIDTH-1:0] stg_q;
  logic [STAGES:0][WIDTH-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_n;
  end

  assign q    = stg_q[STAGES-1];
  assign rise = stg_q[STAGES-1] & ~stg_q[STAGES];
  assign fall = ~stg_q[STAGES-1] & stg_q[STAGES];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             cs_s,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic             sdi_s,
  output logic             rd_start,
  output acc_e             rd_kind,
  output logic             cmd_we,
  output logic [CMD_W-1:0] cmd_data
);
  localparam int CNT_MAX = ADDR_W + CMD_W;
  localparam int CW = $clog2(CNT_MAX + 1);

  logic [CW-1:0]     cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CMD_W-1:0]  wd_q, wd_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] addr_full;
  logic              addr_last;
  acc_e              dec;

  assign addr_full = {sdi_s, addr_q[ADDR_W-1:1]};
  assign dec       = addr_decode(mode, addr_full);
  assign addr_last = cs_s & sclk_rise & (cnt_q == CW'(ADDR_W - 1));

  always_comb begin
    cnt_n  = cnt_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    wr_n   = wr_q;
    if (!cs_s) begin
      cnt_n = '0;
      wr_n  = 1'b0;
    end else if (sclk_rise) begin
      if (cnt_q < CW'(ADDR_W))       addr_n = addr_full;
      else if (cnt_q < CW'(CNT_MAX)) wd_n = {sdi_s, wd_q[CMD_W-1:1]};
      if (cnt_q != CW'(CNT_MAX))     cnt_n = cnt_q + 1'b1;
      if (addr_last && dec == ACC_WR) wr_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      wd_q   <= wd_n;
      wr_q   <= wr_n;
    end
  end

  assign rd_start = addr_last & (dec == ACC_CS || dec == ACC_SQ);
  assign rd_kind  = dec;
  assign cmd_we   = cs_fall & wr_q & (cnt_q == CW'(CNT_MAX));
  assign cmd_data = wd_q;

  assert_load_on_deassert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> (!cs_s && $past(cs_s)));
  assert_read_not_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> !cmd_we);
endmodule

// File: rtl/ser_cmd.sv
module ser_cmd
  import ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             emph_bit,
  input  logic             valid_bit,
  input  logic             raw_in1,
  input  logic             raw_in2,
  output logic             sys_stop,
  output logic             in_sel,
  output logic [1:0]       stat_sel,
  output logic [1:0]       out_fmt,
  output logic             stat_out
);
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic [3:0]       src;

  always_comb begin
    cmd_n = cmd_q;
    if (cmd_we) cmd_n = cmd_data & CMD_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_n;
  end

  assign sys_stop = cmd_q[BIT_STOP];
  assign in_sel   = cmd_q[BIT_INSEL];
  assign stat_sel = {cmd_q[BIT_SSEL_HI], cmd_q[BIT_SSEL_LO]};
  assign out_fmt  = {cmd_q[BIT_FMT_HI], cmd_q[BIT_FMT_LO]};
  assign src      = {raw_in2, raw_in1, valid_bit, emph_bit};
  assign stat_out = src[stat_sel];

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(cmd_q));
endmodule

// File: rtl/ser_readout.sv
module ser_readout
  import ser_pkg::*;
#(
  parameter int CS_BITS = 32,
  parameter int SQ_BITS = 80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               cs_s,
  input  logic               sclk_fall,
  input  logic               rd_start,
  input  acc_e               rd_kind,
  input  logic [CS_BITS-1:0] cs_word,
  input  logic [SQ_BITS-1:0] sq_word,
  input  logic               sq_flag,
  input  logic               lock_err,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               sdo_pull
);
  logic [SQ_BITS-1:0] sr_q, sr_n;
  logic pend_q, pend_n, fval_q, fval_n, act_q, act_n;
  logic drv_q, drv_n, dq_q, dq_n, iscs_q, iscs_n, md_q, md_n;

  always_comb begin
    sr_n = sr_q; pend_n = pend_q; fval_n = fval_q; act_n = act_q;
    drv_n = drv_q; dq_n = dq_q; iscs_n = iscs_q; md_n = md_q;
    if (!cs_s) begin
      act_n = 1'b0; drv_n = 1'b0; pend_n = 1'b0;
      iscs_n = 1'b0; sr_n = '0; dq_n = 1'b0;
    end else if (rd_start) begin
      act_n  = 1'b1;
      drv_n  = 1'b0;
      md_n   = mode;
      iscs_n = (rd_kind == ACC_CS);
      if (rd_kind == ACC_CS) begin
        sr_n   = SQ_BITS'(cs_word);
        pend_n = mode;
        fval_n = 1'b1;
      end else begin
        sr_n   = sq_word;
        pend_n = 1'b1;
        fval_n = sq_flag;
      end
    end else if (act_q && sclk_fall) begin
      drv_n = 1'b1;
      if (pend_q) begin
        dq_n   = fval_q;
        pend_n = 1'b0;
      end else begin
        dq_n = sr_q[0];
        sr_n = {1'b0, sr_q[SQ_BITS-1:1]};
      end
    end
    if (iscs_n && lock_err) sr_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0; pend_q <= 1'b0; fval_q <= 1'b0; act_q <= 1'b0;
      drv_q <= 1'b0; dq_q <= 1'b0; iscs_q <= 1'b0; md_q <= 1'b0;
    end else begin
      sr_q <= sr_n; pend_q <= pend_n; fval_q <= fval_n; act_q <= act_n;
      drv_q <= drv_n; dq_q <= dq_n; iscs_q <= iscs_n; md_q <= md_n;
    end
  end

  assign sdo      = dq_q;
  assign sdo_oe   = drv_q & md_q;
  assign sdo_pull = drv_q & ~md_q & ~dq_q;

  assert_idle_undriven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (!sdo_oe && !sdo_pull));
  assert_flag_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && rd_kind == ACC_CS && mode) |=> (pend_q && fval_q));
  assert_lock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iscs_q && lock_err) |=> (sr_q == '0));
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
  import ser_pkg::*;
#(
  parameter int CS_BITS     = 32,
  parameter int SQ_BITS     = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode,
  input  logic               ser_clk,
  input  logic               ser_cs,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic               ser_dout_oe,
  output logic               ser_dout_pull,
  input  logic [CS_BITS-1:0] cs_word,
  input  logic [SQ_BITS-1:0] sq_word,
  input  logic               sq_crc_ok,
  input  logic               lock_err,
  input  logic               emph_bit,
  input  logic               valid_bit,
  input  logic               raw_in1,
  input  logic               raw_in2,
  output logic               sys_stop,
  output logic               in_sel,
  output logic [1:0]         stat_sel,
  output logic [1:0]         out_fmt,
  output logic               stat_out
);
  logic [2:0] s_q, s_rise, s_fall;
  logic rd_start, cmd_we;
  acc_e rd_kind;
  logic [CMD_W-1:0] cmd_data;

  ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_din, ser_cs, ser_clk}),
    .q(s_q), .rise(s_rise), .fall(s_fall));

  ser_frame u_frame (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_s(s_q[1]), .cs_fall(s_fall[1]),
    .sclk_rise(s_rise[0]), .sdi_s(s_q[2]), .rd_start(rd_start), .rd_kind(rd_kind),
    .cmd_we(cmd_we), .cmd_data(cmd_data));

  ser_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .emph_bit(emph_bit), .valid_bit(valid_bit), .raw_in1(raw_in1), .raw_in2(raw_in2),
    .sys_stop(sys_stop), .in_sel(in_sel), .stat_sel(stat_sel), .out_fmt(out_fmt),
    .stat_out(stat_out));

  ser_readout #(.CS_BITS(CS_BITS), .SQ_BITS(SQ_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_s(s_q[1]), .sclk_fall(s_fall[0]),
    .rd_start(rd_start), .rd_kind(rd_kind), .cs_word(cs_word), .sq_word(sq_word),
    .sq_flag(sq_crc_ok), .lock_err(lock_err), .sdo(ser_dout), .sdo_oe(ser_dout_oe),
    .sdo_pull(ser_dout_pull));
endmodule

// File: tb/ser_ctl_port_test.sv
module ser_ctl_port_test;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst_n, mode, ser_clk, ser_cs, ser_din;
  logic ser_dout, ser_dout_oe, ser_dout_pull;
  logic [31:0] cs_word;
  logic [79:0] sq_word;
  logic sq_crc_ok, lock_err, emph_bit, valid_bit, raw_in1, raw_in2;
  logic sys_stop, in_sel, stat_out;
  logic [1:0] stat_sel, out_fmt;
  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic [7:0] cur_cmd;

  always #10 clk = ~clk;

  ser_ctl_port uut (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b; wait_clk(H); ser_clk = 1'b1; wait_clk(H); ser_clk = 1'b0;
  endtask

  task automatic frame_begin(input logic [7:0] addr);
    ser_cs = 1'b1; wait_clk(H);
    for (int i = 0; i < 8; i++) send_bit(addr[i]);
  endtask

  task automatic frame_end();
    wait_clk(H); ser_cs = 1'b0; wait_clk(3 * H);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [15:0] data, input int nbits);
    frame_begin(addr);
    for (int i = 0; i < nbits; i++) send_bit(data[i]);
    frame_end();
  endtask

  // reads n bits; lock_err is raised right after bit lock_at is sampled (-1: never)
  task automatic do_read(input logic [7:0] addr, input int n, input int lock_at,
                         output logic [127:0] got, output int bad_en);
    got = '0; bad_en = 0;
    frame_begin(addr);
    for (int i = 0; i < n; i++) begin
      wait_clk(H);
      if (mode) begin
        got[i] = ser_dout;
        if (!ser_dout_oe || ser_dout_pull) bad_en++;
      end else begin
        got[i] = ~ser_dout_pull;
        if (ser_dout_oe) bad_en++;
      end
      if (i == lock_at) lock_err = 1'b1;
      ser_clk = 1'b1; wait_clk(H); ser_clk = 1'b0;
    end
    frame_end();
    lock_err = 1'b0;
  endtask

  function automatic logic [127:0] exp_cs(input logic m, input logic [31:0] w);
    return m ? {95'b0, w, 1'b1} : {96'b0, w};
  endfunction

  function automatic logic [127:0] exp_sq(input logic [79:0] w, input logic f);
    return {47'b0, w, f};
  endfunction

  function automatic logic [127:0] mask(input int n);
    return (128'b1 << n) - 1;
  endfunction

  function automatic logic [5:0] exp_fields(input logic [7:0] c);
    return {c[1], c[2], c[3], c[4], c[5], c[6]};
  endfunction

  task automatic check_cmd(input string tag);
    check({sys_stop, in_sel, stat_sel, out_fmt} == exp_fields(cur_cmd), tag,
          {122'b0, sys_stop, in_sel, stat_sel, out_fmt}, {122'b0, exp_fields(cur_cmd)});
  endtask

  task automatic check_stat(input string tag);
    logic e;
    case ({cur_cmd[3], cur_cmd[4]})
      2'b00: e = emph_bit;
      2'b01: e = valid_bit;
      2'b10: e = raw_in1;
      default: e = raw_in2;
    endcase
    wait_clk(1);
    check(stat_out == e, tag, {127'b0, stat_out}, {127'b0, e});
  endtask

  task automatic read_check(input logic [7:0] addr, input bit is_cs, input int n, input string tag);
    logic [127:0] got, exp;
    int bad;
    do_read(addr, n, -1, got, bad);
    exp = is_cs ? exp_cs(mode, cs_word) : exp_sq(sq_word, sq_crc_ok);
    exp = exp & mask(n);
    check(got == exp, tag, got, exp);
    check(bad == 0, {tag, " R10 drive"}, 128'(bad), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] got, exp;
    int bad;
    void'($urandom(32'h1D0C5EED));
    rst_n = 1'b0; mode = 1'b0; ser_clk = 1'b0; ser_cs = 1'b0; ser_din = 1'b0;
    cs_word = 32'hA5C3_0F71; sq_word = 80'h1234_5678_9ABC_DEF0_1357; sq_crc_ok = 1'b1;
    lock_err = 1'b0; emph_bit = 1'b1; valid_bit = 1'b0; raw_in1 = 1'b1; raw_in2 = 1'b0;
    cur_cmd = 8'h00;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);

    // R1 reset state
    check({sys_stop, in_sel, stat_sel, out_fmt, ser_dout_oe, ser_dout_pull} == 8'h00,
          "R1 reset outputs", {120'b0, sys_stop, in_sel, stat_sel, out_fmt, ser_dout_oe, ser_dout_pull}, 128'd0);
    check_stat("R6 emphasis after reset");

    // R2 framing 0 load and reads
    do_write(8'hF7, 16'h007E, 8); cur_cmd = 8'h7E;
    check_cmd("R2 R5 framing-0 load");
    read_check(8'hF8, 1, 32, "R2 R7 framing-0 cs read");
    read_check(8'hF9, 0, 81, "R2 R8 framing-0 subcode read");

    // R5 ignored bits 0 and 7
    do_write(8'hF7, 16'h0081, 8); cur_cmd = 8'h00;
    check_cmd("R5 bits 0 and 7 ignored");

    // R4 short frame leaves command; long frame uses first 8
    do_write(8'hF7, 16'h0014, 8); cur_cmd = 8'h14;
    check_cmd("R4 base load");
    do_write(8'hF7, 16'h00FF, 5);
    check_cmd("R4 short frame ignored");
    do_write(8'hF7, 16'hF00A, 12); cur_cmd = 8'h0A;
    check_cmd("R4 extra bits ignored");

    // R7 bits past payload read 0
    read_check(8'hF8, 1, 36, "R7 trailing zeros framing 0");

    // R9 lock loss mid read
    do_read(8'hF8, 32, 9, got, bad);
    exp = {96'b0, 22'b0, cs_word[9:0]};
    check(got == exp, "R9 lock clears remaining bits", got, exp);

    // R3 framing 1
    mode = 1'b1;
    do_write(8'hF7, 16'h0066, 8);
    check_cmd("R3 framing-0 load address ignored in framing 1");
    do_read(8'hF8, 16, -1, got, bad);
    check(bad == 16, "R3 R10 unknown address leaves output undriven", 128'(bad), 128'd16);
    do_write(8'hEA, 16'h0018, 8); cur_cmd = 8'h18;
    check_cmd("R3 framing-1 load");
    check_stat("R6 raw input 2");
    read_check(8'hE9, 1, 33, "R3 R7 framing-1 cs read with flag");
    sq_crc_ok = 1'b0;
    read_check(8'hE8, 0, 81, "R3 R8 framing-1 subcode read flag low");

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic [7:0] d;
      mode = $urandom_range(0, 1);
      d = 8'($urandom);
      cs_word = $urandom;
      sq_word = {16'($urandom), $urandom, $urandom};
      sq_crc_ok = $urandom_range(0, 1);
      {emph_bit, valid_bit, raw_in1, raw_in2} = 4'($urandom);
      do_write(mode ? 8'hEA : 8'hF7, {8'h00, d}, 8); cur_cmd = d & 8'h7E;
      check_cmd("R4 R5 random load");
      check_stat("R6 random status select");
      read_check(mode ? 8'hE9 : 8'hF8, 1, mode ? 33 : 32, "R7 random cs read");
      read_check(mode ? 8'hE8 : 8'hF9, 0, 81, "R8 random subcode read");
    end

    wait_clk(4);
    check({ser_dout_oe, ser_dout_pull} == 2'b00, "R10 idle undriven",
          {126'b0, ser_dout_oe, ser_dout_pull}, 128'd0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule